// File: doc/BRIEF.md
# Interval Timer Byte-Bus Front End

This block sits between a narrow host bus and a bank of interval-timer counting engines. The host sees four byte locations: one data location per channel (addresses 0 to NCH-1) and a command location at address 3. Command bytes either program a channel's transfer format, counting mode and decimal flag, snapshot its live count, or snapshot the count and/or a status byte of several channels at once. Data bytes go out to the engines as 16-bit load values, one or two bytes per value depending on the programmed format.

On the read side the block answers from a pending status snapshot first, then from a pending count snapshot, and only then from the engine's live count, stepping through low and high bytes as the transfer format requires. The engines report their live count, their output level and a pulse when they have taken a new load value; they do not count in this block.

Bus accesses are single-cycle strobes, one access per cycle. Read data is combinational during the read cycle; the read's side effects take place at the closing clock edge. A load value appears with its strobe in the cycle after the write that completes it.

Top module: `timer_bus_frontend`

## Requirements
- R1: After reset every channel is idle (transfer format 0, mode 0, decimal flag 0), no snapshot is pending, both byte toggles point at the low byte, no load strobe is active, and a status snapshot of an idle channel reads as {OUT, 0, 00, 000, 0}.
- R2: A command write with bits 7:6 = channel and bits 5:4 nonzero sets that channel's transfer format to bits 5:4 (1 low byte only, 2 high byte only, 3 low then high), its mode to bits 3:1 with codes 6 and 7 folded to 2 and 3, and its decimal flag to bit 0; both byte toggles return to the low byte.
- R3: A command write with bits 5:4 = 0 snapshots the addressed channel's live count; later data reads return that snapshot in the channel's transfer format (word format: low byte then high byte) before live reads resume.
- R4: A command with bits 7:6 = 3 acts on every channel i whose bit i+1 is set: bit 5 low snapshots the count, bit 4 low snapshots the status.
- R5: The status byte is OUT at bit 7, null-count at bit 6, transfer format at bits 5:4, mode at bits 3:1 and decimal flag at bit 0.
- R6: A data read returns a pending status snapshot first and clears it with that single read; a pending count snapshot is returned after it.
- R7: A count snapshot request for a channel that already holds an unread count snapshot is ignored, and likewise for status; the first snapshot is the one read.
- R8: In low-only format a data write loads {0x00, byte}; in high-only format it loads {byte, 0x00}; the one-cycle load strobe of that channel rises in the cycle after the write, and at most one strobe is active.
- R9: In word format the first data byte only is held and nothing loads; the second byte loads {second, first}.
- R10: Null-count is set by a programming command or a load and cleared by the channel's taken pulse.
- R11: Unsnapshotted data reads return the live count: low byte, high byte, or in word format alternately low and high starting with low.
- R12: Reading the command location returns 0x00 and changes nothing; data writes to an idle channel load nothing and its data reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 2 | Location: 0..NCH-1 data, 3 command |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid while bus_rd is high |
| cnt_live | input | NCH*16 | Live count of each engine, channel 0 in the low bits |
| cnt_out | input | NCH | Output level of each engine |
| cnt_taken | input | NCH | Engine has taken its new load value |
| load_stb | output | NCH | One-cycle load strobe per channel |
| load_val | output | 16 | Load value for the strobed channel |
| ch_mode | output | NCH*3 | Programmed mode per channel |
| ch_bcd | output | NCH | Programmed decimal flag per channel |

## Verification
A stale byte toggle shows at once as swapped low and high bytes on the next word-format read or as a load with its bytes exchanged. A snapshot that fails to clear, or one overwritten by a second request, shows on the very next data read of that channel as a repeated or wrong byte, so the stimulus interleaves snapshots with changes of the live count. Priority errors between status and count appear on the first read after a combined snapshot.

// File: rtl/tfe_pkg.sv
package tfe_pkg;
  localparam int BW = 8;        // bus byte width
  localparam int CW = 2 * BW;   // count width

  typedef enum logic [1:0] {
    FMT_NONE = 2'd0,
    FMT_LO   = 2'd1,
    FMT_HI   = 2'd2,
    FMT_WORD = 2'd3
  } fmt_e;

  // modes 6 and 7 fold onto 2 and 3
  function automatic logic [2:0] fold_mode(input logic [2:0] m);
    return (m[2:1] == 2'b11) ? {1'b0, m[1:0]} : m;
  endfunction
endpackage

// File: rtl/tfe_cmd_decode.sv
module tfe_cmd_decode #(
  parameter int NCH = 3   // at most 3: select bits are 1..3
) (
  input  logic           wr_cmd,
  input  logic [7:1]     cmd,
  output logic [NCH-1:0] prog,
  output logic [NCH-1:0] snap_cnt,
  output logic [NCH-1:0] snap_sts
);
  logic multi;
  assign multi = (cmd[7:6] == 2'd3);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit         = !multi && (cmd[7:6] == 2'(i));
    assign prog[i]     = wr_cmd && hit && (cmd[5:4] != 2'd0);
    assign snap_cnt[i] = wr_cmd && ((hit && (cmd[5:4] == 2'd0)) ||
                                    (multi && cmd[i+1] && !cmd[5]));
    assign snap_sts[i] = wr_cmd && multi && cmd[i+1] && !cmd[4];
  end
endmodule

// File: rtl/tfe_chan_port.sv
module tfe_chan_port
  import tfe_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog,
  input  logic [5:0]    ctl,
  input  logic          snap_cnt,
  input  logic          snap_sts,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [BW-1:0] wdata,
  input  logic [CW-1:0] live,
  input  logic          out_lvl,
  input  logic          taken,
  output logic [BW-1:0] rdata,
  output logic          load_stb,
  output logic [CW-1:0] load_val,
  output logic [2:0]    mode,
  output logic          bcd
);
  fmt_e          fmt_q, fmt_d, cs_q, cs_d;   // cs: pending count snapshot format
  logic [2:0]    mode_q, mode_d;
  logic          bcd_q, bcd_d, wtg_q, wtg_d, rtg_q, rtg_d;
  logic          ss_q, ss_d, nul_q, nul_d, ld_q, ld_d;
  logic [BW-1:0] wlo_q, wlo_d, ssv_q, ssv_d;
  logic [CW-1:0] csv_q, csv_d, ldv_q, ldv_d;

  // read data: status, then count snapshot, then live
  always_comb begin
    rdata = '0;
    if (ss_q)                 rdata = ssv_q;
    else if (cs_q != FMT_NONE) rdata = (cs_q == FMT_HI) ? csv_q[CW-1:BW] : csv_q[BW-1:0];
    else begin
      unique case (fmt_q)
        FMT_LO:   rdata = live[BW-1:0];
        FMT_HI:   rdata = live[CW-1:BW];
        FMT_WORD: rdata = rtg_q ? live[CW-1:BW] : live[BW-1:0];
        default:  rdata = '0;
      endcase
    end
  end

  always_comb begin
    fmt_d = fmt_q; mode_d = mode_q; bcd_d = bcd_q;
    wtg_d = wtg_q; rtg_d = rtg_q; wlo_d = wlo_q;
    cs_d = cs_q; csv_d = csv_q; ss_d = ss_q; ssv_d = ssv_q;
    nul_d = nul_q; ld_d = 1'b0; ldv_d = ldv_q;

    if (taken) nul_d = 1'b0;

    if (prog) begin
      fmt_d  = fmt_e'(ctl[5:4]);
      mode_d = fold_mode(ctl[3:1]);
      bcd_d  = ctl[0];
      wtg_d  = 1'b0;
      rtg_d  = 1'b0;
      nul_d  = 1'b1;
    end

    if (snap_cnt && cs_q == FMT_NONE) begin
      cs_d  = fmt_q;
      csv_d = live;
    end
    if (snap_sts && !ss_q) begin
      ss_d  = 1'b1;
      ssv_d = {out_lvl, nul_q, fmt_q, mode_q, bcd_q};
    end

    if (wr_en) begin
      unique case (fmt_q)
        FMT_LO: begin ld_d = 1'b1; ldv_d = {{BW{1'b0}}, wdata}; end
        FMT_HI: begin ld_d = 1'b1; ldv_d = {wdata, {BW{1'b0}}}; end
        FMT_WORD: begin
          if (!wtg_q) begin
            wlo_d = wdata;
            wtg_d = 1'b1;
          end else begin
            ld_d  = 1'b1;
            ldv_d = {wdata, wlo_q};
            wtg_d = 1'b0;
          end
        end
        default: ;
      endcase
      if (ld_d) nul_d = 1'b1;
    end

    if (rd_en) begin
      if (ss_q)                   ss_d = 1'b0;
      else if (cs_q == FMT_WORD)  cs_d = FMT_HI;
      else if (cs_q != FMT_NONE)  cs_d = FMT_NONE;
      else if (fmt_q == FMT_WORD) rtg_d = !rtg_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= FMT_NONE; mode_q <= '0; bcd_q <= 1'b0;
      wtg_q <= 1'b0; rtg_q <= 1'b0; wlo_q <= '0;
      cs_q <= FMT_NONE; csv_q <= '0; ss_q <= 1'b0; ssv_q <= '0;
      nul_q <= 1'b0; ld_q <= 1'b0; ldv_q <= '0;
    end else begin
      fmt_q <= fmt_d; mode_q <= mode_d; bcd_q <= bcd_d;
      wtg_q <= wtg_d; rtg_q <= rtg_d; wlo_q <= wlo_d;
      cs_q <= cs_d; csv_q <= csv_d; ss_q <= ss_d; ssv_q <= ssv_d;
      nul_q <= nul_d; ld_q <= ld_d; ldv_q <= ldv_d;
    end
  end

  assign load_stb = ld_q;
  assign load_val = ldv_q;
  assign mode     = mode_q;
  assign bcd      = bcd_q;

  assert_lo_write_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fmt_q == FMT_LO) |=> (load_stb && load_val[CW-1:BW] == '0));
  assert_word_first_byte_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fmt_q == FMT_WORD && !wtg_q) |=> !load_stb);
  assert_status_single_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ss_q && !snap_sts) |=> !ss_q);
  assert_count_snapshot_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_cnt && cs_q != FMT_NONE && !rd_en) |=> $stable(csv_q));
  assert_status_snapshot_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_sts && ss_q && !rd_en) |=> $stable(ssv_q));
endmodule

// File: rtl/timer_bus_frontend.sv
module timer_bus_frontend
  import tfe_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NCH*16-1:0] cnt_live,
  input  logic [NCH-1:0]    cnt_out,
  input  logic [NCH-1:0]    cnt_taken,
  output logic [NCH-1:0]    load_stb,
  output logic [15:0]       load_val,
  output logic [NCH*3-1:0]  ch_mode,
  output logic [NCH-1:0]    ch_bcd
);
  localparam logic [1:0] CMD_ADDR = 2'd3;

  logic [NCH-1:0]   prog, snap_cnt, snap_sts;
  logic [BW-1:0]    ch_rdata [NCH];
  logic [CW-1:0]    ch_ldv   [NCH];
  logic             wr_cmd;

  assign wr_cmd = bus_wr && (bus_addr == CMD_ADDR);

  tfe_cmd_decode #(.NCH(NCH)) u_dec (
    .wr_cmd   (wr_cmd),
    .cmd      (bus_wdata[7:1]),
    .prog     (prog),
    .snap_cnt (snap_cnt),
    .snap_sts (snap_sts)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic sel;
    assign sel = (bus_addr == 2'(i));
    tfe_chan_port u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .prog     (prog[i]),
      .ctl      (bus_wdata[5:0]),
      .snap_cnt (snap_cnt[i]),
      .snap_sts (snap_sts[i]),
      .wr_en    (bus_wr && sel),
      .rd_en    (bus_rd && sel),
      .wdata    (bus_wdata),
      .live     (cnt_live[i*CW +: CW]),
      .out_lvl  (cnt_out[i]),
      .taken    (cnt_taken[i]),
      .rdata    (ch_rdata[i]),
      .load_stb (load_stb[i]),
      .load_val (ch_ldv[i]),
      .mode     (ch_mode[i*3 +: 3]),
      .bcd      (ch_bcd[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (bus_addr == 2'(i)) bus_rdata = ch_rdata[i];
  end

  always_comb begin
    load_val = '0;
    for (int i = 0; i < NCH; i++)
      if (load_stb[i]) load_val = ch_ldv[i];
  end

  assert_one_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_stb));
  assert_cmd_read_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == CMD_ADDR) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/tb_timer_bus_frontend.sv
`timescale 1ns/1ps
module tb_timer_bus_frontend;
  localparam int NCH = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_wr, bus_rd;
  logic [1:0]        bus_addr;
  logic [7:0]        bus_wdata, bus_rdata;
  logic [NCH*16-1:0] cnt_live;
  logic [NCH-1:0]    cnt_out, cnt_taken, load_stb, ch_bcd;
  logic [15:0]       load_val;
  logic [NCH*3-1:0]  ch_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  timer_bus_frontend #(.NCH(NCH)) dut (.*);

  // {is_read, addr, wdata, expected read byte, live count of channel 0}
  localparam int NV = 28;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 2'd3, 8'h34, 8'h00, 16'h1234},  // R2 ch0 word fmt, mode 2
    {1'b1, 2'd0, 8'h00, 8'h34, 16'h1234},  // R11 live lo
    {1'b1, 2'd0, 8'h00, 8'h12, 16'h1234},  // R11 live hi
    {1'b1, 2'd0, 8'h00, 8'h34, 16'h1234},
    {1'b1, 2'd0, 8'h00, 8'h12, 16'h1234},
    {1'b0, 2'd3, 8'h57, 8'h00, 16'h1234},  // R2 ch1 lo fmt, mode 3, bcd
    {1'b1, 2'd1, 8'h00, 8'hCD, 16'h1234},  // R11 lo only
    {1'b1, 2'd1, 8'h00, 8'hCD, 16'h1234},
    {1'b0, 2'd3, 8'hAE, 8'h00, 16'h1234},  // R2 ch2 hi fmt, mode 7 -> 3
    {1'b1, 2'd2, 8'h00, 8'h5A, 16'h1234},  // R11 hi only
    {1'b0, 2'd3, 8'h00, 8'h00, 16'h1234},  // R3 snapshot ch0
    {1'b1, 2'd0, 8'h00, 8'h34, 16'h4321},  // R3 snapshot lo
    {1'b1, 2'd0, 8'h00, 8'h12, 16'h4321},  // R3 snapshot hi
    {1'b1, 2'd0, 8'h00, 8'h21, 16'h4321},  // R3 live resumes
    {1'b0, 2'd3, 8'hC4, 8'h00, 16'h4321},  // R4 count+status ch1
    {1'b1, 2'd1, 8'h00, 8'h57, 16'h4321},  // R5 R6 status first
    {1'b1, 2'd1, 8'h00, 8'hCD, 16'h4321},  // R6 count next
    {1'b1, 2'd1, 8'h00, 8'hCD, 16'h4321},
    {1'b0, 2'd3, 8'hEA, 8'h00, 16'h4321},  // R4 status ch0 and ch2
    {1'b1, 2'd2, 8'h00, 8'hE6, 16'h4321},  // R5 ch2 status
    {1'b1, 2'd2, 8'h00, 8'h5A, 16'h4321},  // R6 cleared after one read
    {1'b0, 2'd3, 8'hD2, 8'h00, 16'h1234},  // R4 count only ch0
    {1'b0, 2'd3, 8'hD2, 8'h00, 16'h5555},  // R7 ignored
    {1'b1, 2'd0, 8'h00, 8'hF4, 16'h5555},  // R6 status before count
    {1'b1, 2'd0, 8'h00, 8'h34, 16'h5555},  // R7 first snapshot kept
    {1'b1, 2'd0, 8'h00, 8'h12, 16'h5555},
    {1'b1, 2'd0, 8'h00, 8'h55, 16'h5555},
    {1'b1, 2'd3, 8'h00, 8'h00, 16'h5555}   // R12 command location read
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 chk(bus_rdata == exp, req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    cnt_live = {16'h5A0F, 16'hABCD, 16'h1234};
    cnt_out = 3'b101; cnt_taken = '0;
    repeat (3) @(negedge clk);
    chk(load_stb == '0, "R1 load strobe", load_stb, 0);
    chk(ch_mode == '0 && ch_bcd == '0, "R1 mode", ch_mode, 0);
    rst_n = 1'b1;
    bus_read(2'd0, 8'h00, "R12 idle read");
    bus_write(2'd0, 8'h55);
    chk(load_stb == '0, "R12 idle write", load_stb, 0);
    bus_write(2'd3, 8'hE2);               // status snapshot ch0
    bus_read(2'd0, 8'h80, "R1 R5 idle status");

    for (int i = 0; i < NV; i++) begin
      cnt_live[15:0] = VEC[i][15:0];
      if (VEC[i][34]) bus_read(VEC[i][33:32], VEC[i][23:16], $sformatf("vector %0d", i));
      else            bus_write(VEC[i][33:32], VEC[i][31:24]);
    end

    chk(ch_mode == {3'd3, 3'd3, 3'd2}, "R2 mode outputs", ch_mode, 9'o332);
    chk(ch_bcd == 3'b010, "R2 bcd outputs", ch_bcd, 2);

    bus_write(2'd1, 8'h77);
    chk(load_stb == 3'b010 && load_val == 16'h0077, "R8 lo load", load_val, 16'h0077);
    bus_write(2'd2, 8'h99);
    chk(load_stb == 3'b100 && load_val == 16'h9900, "R8 hi load", load_val, 16'h9900);
    @(negedge clk);
    chk(load_stb == '0, "R8 strobe one cycle", load_stb, 0);
    bus_write(2'd0, 8'h11);
    chk(load_stb == '0, "R9 first byte held", load_stb, 0);
    bus_write(2'd0, 8'h22);
    chk(load_stb == 3'b001 && load_val == 16'h2211, "R9 word load", load_val, 16'h2211);

    bus_write(2'd3, 8'hE4);               // status ch1
    bus_read(2'd1, 8'h57, "R10 null set");
    @(negedge clk); cnt_taken = 3'b010;
    @(negedge clk); cnt_taken = '0;
    bus_write(2'd3, 8'hE4);
    bus_read(2'd1, 8'h17, "R10 null cleared");
    bus_write(2'd1, 8'h01);
    bus_write(2'd3, 8'hE4);
    bus_read(2'd1, 8'h57, "R10 null set by load");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule